// File: doc/BRIEF.md
# Demand-Allocated Sparse Word Memory

This block is a word-addressed memory front end. It offers a 32-bit address space, but only a small physical pool stands behind it. The address is split into two fields. The high field is a block number and the low field is a word offset inside that block. Pool storage is granted one whole block at a time, and only when software first writes somewhere inside that block. A read from a block that was never written costs nothing and returns zero.

A running usage counter records how many words have been granted so far. The block compares that counter with a fixed word quota. The pool holds exactly as many blocks as the quota allows.

When a write needs a new block, the block does three things in order. It claims the next free pool slot, counting upward. It zeroes that slot one word per cycle. It then stores the write and charges one block's worth of words to the counter. If that charge would carry the counter past the quota, the write is dropped instead and a one-cycle quota exception is raised. Requests use a valid/ready handshake, and every accepted request gets exactly one response pulse.

Top module: `sparse_mem_ctrl`

## Requirements
- R1: During and right after reset, `req_ready` is 1, and `resp_valid` and `exc_valid` are 0. No block is allocated and the usage count is zero.
- R2: `req_addr[ADDR_W-1:OFF_W]` is the block number and `req_addr[OFF_W-1:0]` is the word offset. The defaults are a 16-word block (OFF_W=4) and a 48-word quota. Blocks with different numbers never alias, even when their numbers are adjacent.
- R3: A read from an unallocated block returns zero and allocates nothing. Any number of such reads leaves the full quota's worth of allocations still available.
- R4: The first write to an unallocated block takes a pool slot and adds 2^OFF_W words to the usage count. Every other word of that block then reads as zero.
- R5: If the usage count plus one block would exceed QUOTA_WORDS, the write is dropped and the block stays unallocated, so it still reads zero. The exception pulse comes in the same cycle as that request's response. An allocation that brings the usage count exactly to the quota is accepted.
- R6: A write to an allocated block stores the word, and a later read of that address returns the last value written.
- R7: A request is accepted in a cycle where `req_valid` and `req_ready` are both 1. Each accepted request gets exactly one `resp_valid` pulse. Reads, writes to allocated blocks and quota faults respond one cycle after acceptance. An allocating write responds 2^OFF_W+2 cycles after acceptance, and `req_ready` stays 0 until that response.
- R8: `exc_valid` is high for exactly one cycle per fault, with `exc_code` = 2'b01 (quota fault). `exc_valid` is 0 at all other times.
- R9: Reset clears the block map and the usage count. Blocks written before the reset read as zero afterwards, and the full quota can be allocated again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller can accept a request |
| req_we | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Word address (block number, offset) |
| req_wdata | input | DATA_W | Write data |
| resp_valid | output | 1 | One-cycle completion pulse |
| resp_rdata | output | DATA_W | Read data (zero for writes) |
| exc_valid | output | 1 | One-cycle exception pulse |
| exc_code | output | 2 | Exception code, 2'b01 = quota fault |

## Verification
A quota rejection and a request's completion fall in the same cycle, because a rejected write's response and its exception pulse share one edge. The bench provokes this by filling the pool to exactly the quota and then writing to a fourth, fresh block. In the response cycle it expects `resp_valid`, `exc_valid` and code 01 together. In the next cycle it expects the exception to be gone, and the rejected block must still read zero. Allocations that land exactly on the quota must complete with no exception at all.

// File: rtl/sparse_mem_pkg.sv
package sparse_mem_pkg;

    typedef enum logic [1:0] {
        EXC_NONE  = 2'b00,
        EXC_QUOTA = 2'b01
    } exc_code_e;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'b00,
        ST_CLEAR  = 2'b01,
        ST_COMMIT = 2'b10
    } ctrl_state_e;

    function automatic int width_of(input int count);
        return (count > 1) ? $clog2(count) : 1;
    endfunction

endpackage

// File: rtl/sparse_blk_map.sv
module sparse_blk_map #(
    parameter int TAG_W  = 28,
    parameter int SLOTS  = 3,
    parameter int SLOT_W = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [TAG_W-1:0]  lk_tag,
    output logic              lk_hit,
    output logic [SLOT_W-1:0] lk_slot,
    input  logic              alloc_en,
    input  logic [TAG_W-1:0]  alloc_tag,
    output logic [SLOT_W-1:0] fill_slot
);
    logic [SLOTS-1:0]  match;
    logic [SLOT_W-1:0] fill_q;

    for (genvar i = 0; i < SLOTS; i++) begin : g_entry
        logic             vld_q;
        logic [TAG_W-1:0] tag_q;

        always_ff @(posedge clk) begin
            if (rst) begin
                vld_q <= 1'b0;
                tag_q <= '0;
            end else if (alloc_en && fill_q == SLOT_W'(i)) begin
                vld_q <= 1'b1;
                tag_q <= alloc_tag;
            end
        end

        assign match[i] = vld_q && (tag_q == lk_tag);
    end

    always_comb begin
        lk_slot = '0;
        for (int i = SLOTS - 1; i >= 0; i--) begin
            if (match[i]) lk_slot = SLOT_W'(i);
        end
    end

    assign lk_hit    = |match;
    assign fill_slot = fill_q;

    always_ff @(posedge clk) begin
        if (rst)           fill_q <= '0;
        else if (alloc_en) fill_q <= fill_q + 1'b1;
    end
endmodule

// File: rtl/sparse_pool.sv
module sparse_pool #(
    parameter int DATA_W = 32,
    parameter int IDX_W  = 6
) (
    input  logic              clk,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [DATA_W-1:0] rd_data
);
    localparam int DEPTH = 1 << IDX_W;

    logic [DATA_W-1:0] cells [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en) cells[wr_idx] <= wr_data;
    end

    assign rd_data = cells[rd_idx];
endmodule

// File: rtl/sparse_quota.sv
module sparse_quota #(
    parameter int USE_W       = 7,
    parameter int BLK_WORDS   = 16,
    parameter int QUOTA_WORDS = 48
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             charge,
    output logic             over_quota,
    output logic [USE_W-1:0] usage
);
    localparam logic [USE_W-1:0] STEP  = USE_W'(BLK_WORDS);
    localparam logic [USE_W-1:0] LIMIT = USE_W'(QUOTA_WORDS);

    logic [USE_W-1:0] used_q;

    assign over_quota = (used_q + STEP) > LIMIT;
    assign usage      = used_q;

    always_ff @(posedge clk) begin
        if (rst)         used_q <= '0;
        else if (charge) used_q <= used_q + STEP;
    end
endmodule

// File: rtl/sparse_mem_ctrl.sv
module sparse_mem_ctrl
    import sparse_mem_pkg::*;
#(
    parameter int ADDR_W      = 32,
    parameter int DATA_W      = 32,
    parameter int OFF_W       = 4,
    parameter int QUOTA_WORDS = 48
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_we,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              resp_valid,
    output logic [DATA_W-1:0] resp_rdata,
    output logic              exc_valid,
    output logic [1:0]        exc_code
);
    localparam int BLK_WORDS = 1 << OFF_W;
    localparam int TAG_W     = ADDR_W - OFF_W;
    localparam int SLOTS     = QUOTA_WORDS / BLK_WORDS;
    localparam int SLOT_W    = width_of(SLOTS);
    localparam int IDX_W     = SLOT_W + OFF_W;
    localparam int USE_W     = width_of(QUOTA_WORDS + BLK_WORDS + 1) + 1;

    ctrl_state_e       state_q;
    logic [OFF_W-1:0]  clr_cnt_q;
    logic [TAG_W-1:0]  pend_tag_q;
    logic [OFF_W-1:0]  pend_off_q;
    logic [DATA_W-1:0] pend_data_q;

    logic [TAG_W-1:0]  in_tag;
    logic [OFF_W-1:0]  in_off;
    logic              accept;
    logic              map_hit;
    logic [SLOT_W-1:0] map_slot;
    logic [SLOT_W-1:0] free_slot;
    logic              commit;
    logic              over_quota;
    logic [USE_W-1:0]  usage_words;
    logic              pool_we;
    logic [IDX_W-1:0]  pool_widx;
    logic [DATA_W-1:0] pool_wdata;
    logic [DATA_W-1:0] pool_rdata;

    assign in_tag    = req_addr[ADDR_W-1:OFF_W];
    assign in_off    = req_addr[OFF_W-1:0];
    assign req_ready = (state_q == ST_IDLE);
    assign accept    = req_valid && req_ready;
    assign commit    = (state_q == ST_COMMIT);

    sparse_blk_map #(.TAG_W(TAG_W), .SLOTS(SLOTS), .SLOT_W(SLOT_W)) u_map (
        .clk      (clk),
        .rst      (rst),
        .lk_tag   (in_tag),
        .lk_hit   (map_hit),
        .lk_slot  (map_slot),
        .alloc_en (commit),
        .alloc_tag(pend_tag_q),
        .fill_slot(free_slot)
    );

    sparse_quota #(.USE_W(USE_W), .BLK_WORDS(BLK_WORDS), .QUOTA_WORDS(QUOTA_WORDS)) u_quota (
        .clk       (clk),
        .rst       (rst),
        .charge    (commit),
        .over_quota(over_quota),
        .usage     (usage_words)
    );

    sparse_pool #(.DATA_W(DATA_W), .IDX_W(IDX_W)) u_pool (
        .clk    (clk),
        .wr_en  (pool_we),
        .wr_idx (pool_widx),
        .wr_data(pool_wdata),
        .rd_idx ({map_slot, in_off}),
        .rd_data(pool_rdata)
    );

    // Pool write source: direct hit, zero fill of a fresh slot, or the held write.
    always_comb begin
        pool_we    = 1'b0;
        pool_widx  = {map_slot, in_off};
        pool_wdata = req_wdata;
        unique case (state_q)
            ST_IDLE:   pool_we = accept && req_we && map_hit;
            ST_CLEAR: begin
                pool_we    = 1'b1;
                pool_widx  = {free_slot, clr_cnt_q};
                pool_wdata = '0;
            end
            ST_COMMIT: begin
                pool_we    = 1'b1;
                pool_widx  = {free_slot, pend_off_q};
                pool_wdata = pend_data_q;
            end
            default: pool_we = 1'b0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q     <= ST_IDLE;
            clr_cnt_q   <= '0;
            pend_tag_q  <= '0;
            pend_off_q  <= '0;
            pend_data_q <= '0;
            resp_valid  <= 1'b0;
            resp_rdata  <= '0;
            exc_valid   <= 1'b0;
            exc_code    <= EXC_NONE;
        end else begin
            resp_valid <= 1'b0;
            exc_valid  <= 1'b0;
            exc_code   <= EXC_NONE;
            unique case (state_q)
                ST_IDLE: if (accept) begin
                    if (!req_we) begin
                        resp_valid <= 1'b1;
                        resp_rdata <= map_hit ? pool_rdata : '0;
                    end else if (map_hit) begin
                        resp_valid <= 1'b1;
                        resp_rdata <= '0;
                    end else if (over_quota) begin
                        resp_valid <= 1'b1;
                        resp_rdata <= '0;
                        exc_valid  <= 1'b1;
                        exc_code   <= EXC_QUOTA;
                    end else begin
                        state_q     <= ST_CLEAR;
                        clr_cnt_q   <= '0;
                        pend_tag_q  <= in_tag;
                        pend_off_q  <= in_off;
                        pend_data_q <= req_wdata;
                    end
                end
                ST_CLEAR: begin
                    clr_cnt_q <= clr_cnt_q + 1'b1;
                    if (clr_cnt_q == OFF_W'(BLK_WORDS - 1)) state_q <= ST_COMMIT;
                end
                ST_COMMIT: begin
                    state_q    <= ST_IDLE;
                    resp_valid <= 1'b1;
                    resp_rdata <= '0;
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/sparse_mem_ctrl_chk.sv
module sparse_mem_ctrl_chk #(
    parameter int USE_W       = 7,
    parameter int BLK_WORDS   = 16,
    parameter int QUOTA_WORDS = 48
) (
    input logic             clk,
    input logic             rst,
    input logic             req_valid,
    input logic             req_ready,
    input logic             resp_valid,
    input logic             exc_valid,
    input logic [1:0]       exc_code,
    input logic [USE_W-1:0] usage
);
    assert_usage_cap_R5: assert property (@(posedge clk) disable iff (rst)
        int'(usage) <= QUOTA_WORDS);

    assert_exc_one_cycle_R8: assert property (@(posedge clk) disable iff (rst)
        exc_valid |=> !exc_valid);

    assert_exc_with_resp_R5: assert property (@(posedge clk) disable iff (rst)
        exc_valid |-> (resp_valid && exc_code == 2'b01));

    assert_fault_no_charge_R5: assert property (@(posedge clk) disable iff (rst)
        exc_valid |-> (usage == $past(usage)));

    assert_charge_one_block_R4: assert property (@(posedge clk) disable iff (rst)
        (usage != $past(usage)) |->
            (resp_valid && !exc_valid && int'(usage) == int'($past(usage)) + BLK_WORDS));

    assert_accept_answers_R7: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready) |=> (resp_valid || !req_ready));

    assert_busy_silent_R7: assert property (@(posedge clk) disable iff (rst)
        !req_ready |-> (!resp_valid && !exc_valid));
endmodule

bind sparse_mem_ctrl sparse_mem_ctrl_chk #(
    .USE_W(USE_W),
    .BLK_WORDS(BLK_WORDS),
    .QUOTA_WORDS(QUOTA_WORDS)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .resp_valid(resp_valid),
    .exc_valid (exc_valid),
    .exc_code  (exc_code),
    .usage     (usage_words)
);

// File: tb/sparse_mem_ctrl_tb.sv
module sparse_mem_ctrl_tb;
    localparam int CLK_PERIOD = 10;
    localparam int OFF_W      = 4;
    localparam int BLK        = 1 << OFF_W;
    localparam int QUOTA      = 48;
    localparam int ALLOC_LAT  = BLK + 2;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic        req_we = 1'b0;
    logic [31:0] req_addr = '0;
    logic [31:0] req_wdata = '0;
    logic        resp_valid;
    logic [31:0] resp_rdata;
    logic        exc_valid;
    logic [1:0]  exc_code;

    int total = 0;
    int bad   = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    sparse_mem_ctrl #(.ADDR_W(32), .DATA_W(32), .OFF_W(OFF_W), .QUOTA_WORDS(QUOTA)) u_dut (
        .clk       (clk),
        .rst       (rst),
        .req_valid (req_valid),
        .req_ready (req_ready),
        .req_we    (req_we),
        .req_addr  (req_addr),
        .req_wdata (req_wdata),
        .resp_valid(resp_valid),
        .resp_rdata(resp_rdata),
        .exc_valid (exc_valid),
        .exc_code  (exc_code)
    );

    // Block base addresses: lowest and highest block numbers, a middle one,
    // and the neighbour of the lowest.
    localparam logic [31:0] BASE_A = 32'h0000_0000;
    localparam logic [31:0] BASE_B = 32'hFFFF_FFF0;
    localparam logic [31:0] BASE_C = 32'h1234_5670;
    localparam logic [31:0] BASE_D = 32'h0000_0010;

    function automatic logic [31:0] pat(input int blk, input int off);
        return 32'h8000_0000 | (32'(blk) << 20) | (32'(off) * 32'h0001_0203) | 32'h1;
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    logic [31:0] r_data;
    int          r_lat;
    logic        r_exc;
    logic [1:0]  r_code;
    logic        r_rdy_seen;
    logic        r_exc_after;
    logic        r_resp_after;

    task automatic do_req(input logic we, input logic [31:0] a, input logic [31:0] d);
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        req_valid = 1'b1;
        req_we    = we;
        req_addr  = a;
        req_wdata = d;
        @(negedge clk);
        req_valid  = 1'b0;
        r_lat      = 1;
        r_rdy_seen = 1'b0;
        while (!resp_valid && r_lat < 100) begin
            if (req_ready) r_rdy_seen = 1'b1;
            @(negedge clk);
            r_lat++;
        end
        r_data = resp_rdata;
        r_exc  = exc_valid;
        r_code = exc_code;
        @(negedge clk);
        r_exc_after  = exc_valid;
        r_resp_after = resp_valid;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        @(negedge clk);
        check("R1 ready in reset", 32'(req_ready), 32'd1);
        check("R1 resp in reset", 32'(resp_valid), 32'd0);
        check("R1 exc in reset", 32'(exc_valid), 32'd0);
        rst = 1'b0;
        @(negedge clk);
        check("R1 ready after reset", 32'(req_ready), 32'd1);
        check("R1 resp after reset", 32'(resp_valid), 32'd0);
        check("R1 exc after reset", 32'(exc_valid), 32'd0);
    endtask

    task automatic alloc_ok(input string req, input logic [31:0] a, input logic [31:0] d);
        do_req(1'b1, a, d);
        check({req, " alloc latency"}, 32'(r_lat), 32'(ALLOC_LAT));
        check({req, " ready low while allocating"}, 32'(r_rdy_seen), 32'd0);
        check({req, " no exception"}, 32'(r_exc), 32'd0);
        check({req, " single response"}, 32'(r_resp_after), 32'd0);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        bad++;
        total++;
        $display("FAIL watchdog actual=hung expected=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        do_reset();

        // R3: unallocated reads return zero in one cycle
        for (int i = 0; i < 6; i++) begin
            do_req(1'b0, 32'h0100_0000 * 32'(i) + 32'(i * 3), 32'h0);
            check("R3 unallocated read data", r_data, 32'h0);
            check("R7 read latency", 32'(r_lat), 32'd1);
            check("R8 no exception on read", 32'(r_exc), 32'd0);
        end

        // R4: first write to block A allocates and clears it
        alloc_ok("R4", BASE_A + 32'd5, 32'hCAFE_0005);
        for (int o = 0; o < BLK; o++) begin
            do_req(1'b0, BASE_A + 32'(o), 32'h0);
            check("R4 fresh block contents", r_data, (o == 5) ? 32'hCAFE_0005 : 32'h0);
        end

        // R6: hits store in one cycle
        for (int o = 0; o < BLK; o++) begin
            do_req(1'b1, BASE_A + 32'(o), pat(0, o));
            check("R7 hit write latency", 32'(r_lat), 32'd1);
            check("R6 hit write no exception", 32'(r_exc), 32'd0);
        end
        do_req(1'b1, BASE_A + 32'd3, 32'h1357_9BDF);
        do_req(1'b0, BASE_A + 32'd3, 32'h0);
        check("R6 overwrite", r_data, 32'h1357_9BDF);
        do_req(1'b1, BASE_A + 32'd3, pat(0, 3));

        // R5 boundary: B then C bring usage exactly to the quota
        alloc_ok("R4 block B", BASE_B + 32'd15, pat(1, 15));
        alloc_ok("R5 exact quota block C", BASE_C, pat(2, 0));
        for (int o = 0; o < BLK; o++) begin
            do_req(1'b1, BASE_B + 32'(o), pat(1, o));
            do_req(1'b1, BASE_C + 32'(o), pat(2, o));
        end

        // R2: sweep all words of all three blocks
        for (int b = 0; b < 3; b++) begin
            for (int o = 0; o < BLK; o++) begin
                logic [31:0] base;
                base = (b == 0) ? BASE_A : (b == 1) ? BASE_B : BASE_C;
                do_req(1'b0, base + 32'(o), 32'h0);
                check("R2 sweep readback", r_data, pat(b, o));
            end
        end
        for (int o = 0; o < BLK; o++) begin
            do_req(1'b0, BASE_D + 32'(o), 32'h0);
            check("R2 neighbour block does not alias", r_data, 32'h0);
        end

        // R5/R8: fourth block exceeds quota; fault and response coincide
        for (int k = 0; k < 2; k++) begin
            do_req(1'b1, BASE_D + 32'd7, 32'hDEAD_BEEF);
            check("R7 fault latency", 32'(r_lat), 32'd1);
            check("R5 exception with response", 32'(r_exc), 32'd1);
            check("R8 exception code", 32'(r_code), 32'd1);
            check("R8 exception one cycle", 32'(r_exc_after), 32'd0);
            do_req(1'b0, BASE_D + 32'd7, 32'h0);
            check("R5 dropped write reads zero", r_data, 32'h0);
            check("R8 no exception on read", 32'(r_exc), 32'd0);
        end
        do_req(1'b1, BASE_A + 32'd9, 32'h0BAD_F00D);
        check("R6 hit after fault no exception", 32'(r_exc), 32'd0);
        do_req(1'b0, BASE_A + 32'd9, 32'h0);
        check("R6 hit after fault data", r_data, 32'h0BAD_F00D);

        // R9: reset empties the map and the usage count
        do_reset();
        for (int o = 0; o < BLK; o += 5) begin
            do_req(1'b0, BASE_A + 32'(o), 32'h0);
            check("R9 old block reads zero", r_data, 32'h0);
        end
        alloc_ok("R9 realloc B", BASE_B + 32'd1, 32'h1111_0001);
        alloc_ok("R9 realloc C", BASE_C + 32'd2, 32'h2222_0002);
        alloc_ok("R9 realloc D", BASE_D + 32'd3, 32'h3333_0003);
        do_req(1'b0, BASE_D + 32'd3, 32'h0);
        check("R9 realloc data", r_data, 32'h3333_0003);
        do_req(1'b0, BASE_D + 32'd4, 32'h0);
        check("R4 cleared neighbour word", r_data, 32'h0);
        do_req(1'b1, BASE_A, 32'h4444_0000);
        check("R9 quota reached again", 32'(r_exc), 32'd1);
        check("R8 code after reset", 32'(r_code), 32'd1);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule